// File: doc/BRIEF.md
# Transmit Frame Length and Heartbeat Monitor

This block sits beside a MAC transmitter. It watches the byte stream that goes out and the collision line from the transceiver. It reports two faults, and each one appears as a single-cycle set pulse that a status register elsewhere can latch.

The first fault is an oversized frame. A counter counts the byte strobes of the current frame; preamble and start-of-frame delimiter bytes never produce a strobe. When the count reaches the configured limit of 1519, the block raises the length-fault pulse. The frame itself is not touched: transmission goes on until the MAC ends it.

The second fault is a missing heartbeat. A healthy transceiver asserts collision briefly during or shortly after each transmission as a self-test. If collision stays low for the whole frame and for a fixed window after the frame ends, the block raises the heartbeat-fault pulse. The window is a parameter given in clock cycles; 4.0 µs is 200 cycles at 50 MHz. A new frame may start while the window of the previous frame is still open. In that case the pending verdict is settled at the start of the new frame.

Top module: `txBabbleHeartbeatMon`

## Requirements
- R1: While `rstN` is low, and after reset until a frame has run, `babbleSet` and `heartbeatErrSet` are both 0.
- R2: `babbleSet` is 1 for exactly one cycle. That cycle follows the clock edge that samples the MAX_BYTES-th byte strobe (default 1519) of the current frame, counting only edges where `txActive` is 1.
- R3: A byte strobe sampled while `txActive` is 0 is ignored. It never adds to any frame's count.
- R4: `babbleSet` pulses at most once per frame, however many strobes follow. The monitor has no output that could end or alter the frame.
- R5: The byte count restarts at each rising edge of `txActive`. A frame of MAX_BYTES-1 strobes gives no pulse, whatever the frames before it held.
- R6: If collision is sampled high at any edge where `txActive` is 1, that frame gives no heartbeat fault.
- R7: The post-frame window is the first WINDOW_CYCLES edges that sample `txActive` at 0 after a frame. A collision at any of those edges, including the last one, counts as a valid heartbeat.
- R8: If no collision is seen during the frame or its window, `heartbeatErrSet` is 1 for exactly one cycle. That cycle follows the WINDOW_CYCLES-th edge of the window.
- R9: A collision sampled outside any frame and its window is ignored. This includes idle time and the edges after the window closes.
- R10: If `txActive` rises while a window is still open, the previous frame's verdict is taken at that edge. The verdict counts only collisions sampled before that edge, so a collision at the restart edge belongs to the new frame. A fault pulse follows the restart edge if no collision was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txActive | input | 1 | High while a frame is being transmitted |
| byteStrobe | input | 1 | One per transmitted frame byte after the preamble and delimiter |
| collision | input | 1 | Collision input from the transceiver |
| babbleSet | output | 1 | One-cycle pulse: frame reached the length limit |
| heartbeatErrSet | output | 1 | One-cycle pulse: no heartbeat seen for the last frame |

## Verification
A byte counter that is off by one shows up directly. The length pulse appears one cycle early or late on a frame of exactly the limit, or it fires on a frame one byte short. A counter that is not cleared, or that counts idle strobes, gives a false pulse on the next short frame. A heartbeat flag or window timer in the wrong state shows up as a fault pulse that is missing, extra or shifted. This is visible within WINDOW_CYCLES cycles of the frame end, or at the restart edge when a new frame cuts the window short. Collisions placed on the last edge inside the window and the first edge outside it pin the window length to the exact cycle.

// File: rtl/txMonPkg.sv
package txMonPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TX   = 2'd1,
    PH_WIN  = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRestart;  // count <= cntInc ? 1 : 0
    logic cntInc;      // count one byte
    logic seenLoad;    // seen <= collision
    logic seenAcc;     // seen <= seen | collision
    logic tmrStart;    // timer <= 1 (first window edge consumed)
    logic tmrInc;      // timer <= timer + 1
  } dpCtrl_t;

endpackage

// File: rtl/txMonDatapath.sv
module txMonDatapath
  import txMonPkg::*;
#(
  parameter int MAX_BYTES     = 1519,
  parameter int WINDOW_CYCLES = 200
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctrl,
  input  logic    collision,
  output logic    cntPreMax,
  output logic    cntAtMax,
  output logic    tmrLast,
  output logic    seen
);

  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam int TW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] CNT_PRE = CW'(MAX_BYTES - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_BYTES);
  localparam logic [TW-1:0] TMR_END = TW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] byteCount;
  logic [TW-1:0] winTimer;
  logic          seenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCount <= '0;
    end else if (ctrl.cntRestart) begin
      byteCount <= ctrl.cntInc ? CW'(1) : '0;
    end else if (ctrl.cntInc) begin
      byteCount <= byteCount + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winTimer <= '0;
    end else if (ctrl.tmrStart) begin
      winTimer <= TW'(1);
    end else if (ctrl.tmrInc) begin
      winTimer <= winTimer + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenQ <= 1'b0;
    end else if (ctrl.seenLoad) begin
      seenQ <= collision;
    end else if (ctrl.seenAcc) begin
      seenQ <= seenQ | collision;
    end
  end

  assign cntPreMax = (byteCount == CNT_PRE);
  assign cntAtMax  = (byteCount == CNT_MAX);
  assign tmrLast   = (winTimer == TMR_END);
  assign seen      = seenQ;

endmodule

// File: rtl/txMonControl.sv
module txMonControl
  import txMonPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txActive,
  input  logic    byteStrobe,
  input  logic    collision,
  input  logic    cntPreMax,
  input  logic    cntAtMax,
  input  logic    tmrLast,
  input  logic    seen,
  output dpCtrl_t ctrl,
  output logic    babbleSet,
  output logic    heartbeatErrSet
);

  phase_t phase, phaseNext;
  logic   babbleNext, hbErrNext;

  always_comb begin
    ctrl       = '0;
    phaseNext  = phase;
    babbleNext = 1'b0;
    hbErrNext  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (txActive) begin
          phaseNext       = PH_TX;
          ctrl.cntRestart = 1'b1;
          ctrl.cntInc     = byteStrobe;
          ctrl.seenLoad   = 1'b1;
        end
      end
      PH_TX: begin
        ctrl.seenAcc = 1'b1;
        if (txActive) begin
          ctrl.cntInc = byteStrobe & ~cntAtMax;
          babbleNext  = byteStrobe & cntPreMax;
        end else begin
          phaseNext     = PH_WIN;
          ctrl.tmrStart = 1'b1;
        end
      end
      PH_WIN: begin
        if (txActive) begin
          // pending verdict uses collisions seen before this edge
          hbErrNext       = ~seen;
          phaseNext       = PH_TX;
          ctrl.cntRestart = 1'b1;
          ctrl.cntInc     = byteStrobe;
          ctrl.seenLoad   = 1'b1;
        end else if (tmrLast) begin
          hbErrNext = ~(seen | collision);
          phaseNext = PH_IDLE;
        end else begin
          ctrl.seenAcc = 1'b1;
          ctrl.tmrInc  = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase           <= PH_IDLE;
      babbleSet       <= 1'b0;
      heartbeatErrSet <= 1'b0;
    end else begin
      phase           <= phaseNext;
      babbleSet       <= babbleNext;
      heartbeatErrSet <= hbErrNext;
    end
  end

endmodule

// File: rtl/txBabbleHeartbeatMon.sv
module txBabbleHeartbeatMon
  import txMonPkg::*;
#(
  parameter int MAX_BYTES     = 1519,  // at least 2
  parameter int WINDOW_CYCLES = 200    // at least 2; 4.0 us at 50 MHz
) (
  input  logic clk,
  input  logic rstN,
  input  logic txActive,
  input  logic byteStrobe,
  input  logic collision,
  output logic babbleSet,
  output logic heartbeatErrSet
);

  dpCtrl_t ctrl;
  logic    cntPreMax, cntAtMax, tmrLast, seen;

  txMonControl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .txActive        (txActive),
    .byteStrobe      (byteStrobe),
    .collision       (collision),
    .cntPreMax       (cntPreMax),
    .cntAtMax        (cntAtMax),
    .tmrLast         (tmrLast),
    .seen            (seen),
    .ctrl            (ctrl),
    .babbleSet       (babbleSet),
    .heartbeatErrSet (heartbeatErrSet)
  );

  txMonDatapath #(
    .MAX_BYTES     (MAX_BYTES),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .collision (collision),
    .cntPreMax (cntPreMax),
    .cntAtMax  (cntAtMax),
    .tmrLast   (tmrLast),
    .seen      (seen)
  );

endmodule

// File: rtl/txBabbleHeartbeatMonChecker.sv
module txBabbleHeartbeatMonChecker (
  input logic clk,
  input logic rstN,
  input logic txActive,
  input logic byteStrobe,
  input logic collision,
  input logic babbleSet,
  input logic heartbeatErrSet
);

  logic txPrev;
  logic babbleInFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPrev        <= 1'b0;
      babbleInFrame <= 1'b0;
    end else begin
      txPrev <= txActive;
      if (txActive && !txPrev) babbleInFrame <= 1'b0;
      else if (babbleSet)      babbleInFrame <= 1'b1;
    end
  end

  // R2: a length pulse follows a counted strobe inside a frame
  assert_babble_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    babbleSet |-> ($past(txActive) && $past(byteStrobe)));

  // R4: at most one length pulse per frame
  assert_babble_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    babbleSet |-> !babbleInFrame);

  // R8: heartbeat fault is a single-cycle pulse
  assert_hb_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    heartbeatErrSet |=> !heartbeatErrSet);

  // R10: a heartbeat verdict never lands in the middle of a frame
  assert_hb_not_midframe_R10: assert property (@(posedge clk) disable iff (!rstN)
    heartbeatErrSet |-> !$past(txActive, 2));

endmodule

bind txBabbleHeartbeatMon txBabbleHeartbeatMonChecker u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .txActive        (txActive),
  .byteStrobe      (byteStrobe),
  .collision       (collision),
  .babbleSet       (babbleSet),
  .heartbeatErrSet (heartbeatErrSet)
);

// File: tb/sim_txBabbleHeartbeatMon.sv
module sim_txBabbleHeartbeatMon;

  localparam int MAXB = 1519;
  localparam int WIN  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txActive = 1'b0;
  logic byteStrobe = 1'b0;
  logic collision = 1'b0;
  logic babbleSet, heartbeatErrSet;

  always #10 clk = ~clk;  // 50 MHz

  txBabbleHeartbeatMon #(.MAX_BYTES(MAXB), .WINDOW_CYCLES(WIN)) u0 (
    .clk             (clk),
    .rstN            (rstN),
    .txActive        (txActive),
    .byteStrobe      (byteStrobe),
    .collision       (collision),
    .babbleSet       (babbleSet),
    .heartbeatErrSet (heartbeatErrSet)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curReq = "R1";

  // reference model, written from the requirements
  bit mPrev = 0;
  int mBytes = 0;
  bit mSeen = 0;
  int mRemain = 0;
  bit expB = 0;
  bit expH = 0;

  function automatic bit verdict(bit seenFlag);
    return !seenFlag;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      mPrev = 0; mBytes = 0; mSeen = 0; mRemain = 0; expB = 0; expH = 0;
    end else begin
      expB = 0;
      expH = 0;
      if (txActive && !mPrev) begin
        if (mRemain > 0) begin
          expH = verdict(mSeen);
          mRemain = 0;
        end
        mBytes = 0;
        mSeen = 0;
      end
      if (txActive) begin
        if (collision) mSeen = 1;
        if (byteStrobe) begin
          mBytes++;
          if (mBytes == MAXB) expB = 1;
        end
      end else if (mPrev) begin
        mRemain = WIN;
      end
      if (!txActive && mRemain > 0) begin
        if (collision) mSeen = 1;
        mRemain--;
        if (mRemain == 0) expH = verdict(mSeen);
      end
      mPrev = txActive;
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b",
               req, what, cycles, act, exp);
    end
  endtask

  task automatic step(bit t, bit b, bit c);
    txActive   = t;
    byteStrobe = b;
    collision  = c;
    @(posedge clk);
    @(negedge clk);
    check(curReq, "babbleSet", babbleSet, expB);
    check(curReq, "heartbeatErrSet", heartbeatErrSet, expH);
  endtask

  // nBytes strobes at density dens%; collision on tx cycle colTx or on
  // gap cycle colGap (gap cycle 0 is window edge 1); -1 means none
  task automatic runFrame(int nBytes, int dens, int colTx, int colGap, int gap);
    int sent = 0;
    int k = 0;
    while (sent < nBytes) begin
      bit s = (($urandom % 100) < dens);
      step(1'b1, s, k == colTx);
      if (s) sent++;
      k++;
    end
    for (int g = 0; g < gap; g++) step(1'b0, 1'($urandom % 2), g == colGap);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state, with busy inputs
    repeat (4) begin
      txActive = 1'b1; byteStrobe = 1'b1; collision = 1'b0;
      @(negedge clk);
      check("R1", "babbleSet in reset", babbleSet, 1'b0);
      check("R1", "heartbeatErrSet in reset", heartbeatErrSet, 1'b0);
    end
    txActive = 1'b0; byteStrobe = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0);

    // R3 and R9: idle strobes and collisions are ignored
    curReq = "R3";
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 1'($urandom % 2));
    curReq = "R3";
    runFrame(1000, 100, 3, -1, WIN + 300);
    runFrame(600, 100, 3, -1, WIN + 5);

    curReq = "R2";
    runFrame(MAXB, 100, 0, -1, WIN + 5);
    curReq = "R2";
    runFrame(MAXB, 55, 10, -1, WIN + 5);
    curReq = "R4";
    runFrame(1800, 80, 5, -1, WIN + 5);
    curReq = "R5";
    runFrame(MAXB - 1, 100, 7, -1, WIN + 5);

    curReq = "R6";
    runFrame(50, 100, 49, -1, WIN + 5);
    curReq = "R7";
    runFrame(50, 100, -1, 0, WIN + 5);
    curReq = "R7";
    runFrame(50, 100, -1, WIN - 1, WIN + 5);
    curReq = "R8";
    runFrame(50, 100, -1, -1, WIN + 5);
    curReq = "R9";
    runFrame(50, 100, -1, WIN, WIN + 5);

    // R10: restart inside the window
    curReq = "R10";
    runFrame(40, 100, -1, -1, 5);
    runFrame(40, 100, 0, -1, 6);
    runFrame(40, 100, -1, 2, 6);
    runFrame(40, 100, 1, -1, WIN + 5);

    // random mix
    curReq = "random R2 R5 R6 R7 R8 R10";
    for (int f = 0; f < 22; f++) begin
      int n    = 1 + int'($urandom % 1700);
      int d    = 60 + int'($urandom % 41);
      int mode = int'($urandom % 4);
      int gap  = 1 + int'($urandom % (WIN + 60));
      int cTx  = (mode == 1) ? int'($urandom % (n + 1)) : -1;
      int cGap = (mode == 2) ? int'($urandom % (WIN + 20)) : -1;
      runFrame(n, d, cTx, cGap, gap);
    end
    curReq = "random R8";
    for (int i = 0; i < WIN + 5; i++) step(1'b0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d cycles expected=fewer", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule